// File: doc/BRIEF.md
# Synchronous Termination Latency Unit

This block sits in the command path of a DDR3-class memory device. It watches the external termination-enable pin on each rising clock edge and produces the internal termination-enable signal after a delay taken from the write path. That delay is the write latency minus two, where the write latency is the CAS write latency plus the additive latency. The additive latency is decoded from a two-bit mode field. The unit also decides whether synchronous termination timing applies at all. While it does not apply, the output is held low and all samples still in flight are discarded.

A second function checks the minimum-high rules on the termination pin. Once the pin has been taken high, it must stay high for a minimum number of cycles. A write that arrives while the pin is high extends that minimum, by a short window for a chopped burst and by a longer one for a full burst. Any breach sets a sticky flag, which holds until it is cleared.

The unit carries no data stream, so it has no valid/ready handshake and never applies back-pressure. Every pin is a plain level or a single-cycle strobe, sampled on the rising edge of `clk`.

Top module: `odt_sync_unit`

## Requirements
- R1: After reset, `odt_term_on`, `err_hold`, `err_write` and `cfg_err` are 0, and the latency is DEF_LAT (3 with the defaults).
- R2: The latency is `cwl + al - 2`, where the additive latency `al` is decoded from `al_code` as 2'b00 → 0, 2'b01 → `cl`-1 and 2'b10 → `cl`-2 (each floored at 0). Suppose the pin is sampled high at edge k and was low before. Then `odt_term_on` first reads 1 after edge k+latency.
- R3: Suppose the pin is sampled low at edge k after a run of highs. Then `odt_term_on` first reads 0 after edge k+latency, so the turn-off latency equals the turn-on latency.
- R4: A computed latency below 1 is used as 1, and one above DEPTH is used as DEPTH.
- R5: A load with `al_code` = 2'b11 (reserved) sets `cfg_err` and leaves the latency unchanged.
- R6: The latency is captured only in a cycle where `mode_load` is 1. Changing `cwl`, `cl` or `al_code` at any other time has no effect.
- R7: Synchronous mode is active when all of the following hold:
  - `dll_locked` = 1;
  - `term_en` = 1;
  - at least one of `cke` = 1, `pd_act_bank` = 1 (active power-down) or `pd_dll_kept` = 1 (precharge power-down with the DLL kept running).
- R8: When synchronous mode is inactive, `odt_term_on` is 0 from the next edge on. All samples in flight are discarded, so no earlier high emerges after the mode returns.
- R9: Suppose the pin is sampled low at edge k after going high at edge j, and k-j < ODTH4 (4). Then `err_hold` is 1 after edge k and stays 1 until cleared.
- R10: Suppose a write (`wr_cmd` = 1) is sampled at edge w while the pin is high, and the pin is then sampled low at edge k with k-w below 4 (`wr_bl8` = 0) or below 6 (`wr_bl8` = 1). Then `err_write` is 1 after edge k and stays 1 until cleared. A write sampled while the pin is low has no effect on `err_write`.
- R11: `err_clr` = 1 clears `err_hold`, `err_write` and `cfg_err` at the next edge. A violation that falls in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable level |
| dll_locked | input | 1 | DLL on and locked |
| term_en | input | 1 | Nominal termination enabled |
| pd_act_bank | input | 1 | Active power-down state |
| pd_dll_kept | input | 1 | Precharge power-down with DLL kept on |
| mode_load | input | 1 | Capture latency fields this cycle |
| cwl | input | 4 | CAS write latency |
| cl | input | 5 | CAS read latency, used for additive latency |
| al_code | input | 2 | Additive latency code |
| odt_pin | input | 1 | External termination-enable pin |
| wr_cmd | input | 1 | Write command registered this cycle |
| wr_bl8 | input | 1 | Write is burst 8 (1) or chopped burst 4 (0) |
| err_clr | input | 1 | Clear all sticky flags |
| odt_term_on | output | 1 | Delayed internal termination enable |
| err_hold | output | 1 | Sticky minimum-high violation |
| err_write | output | 1 | Sticky write hold violation |
| cfg_err | output | 1 | Sticky reserved additive-latency code |

## Verification
The bench builds the unit with DEPTH = 16, ODTH4 = 4, ODTH8 = 6 and DEF_LAT = 3. With a 16-stage line, a write latency of 10 with additive latency 10 pushes the computed value past the top and exercises the upper clamp. Field sets that sum to 2 or 3 reach the lower clamp and the one-cycle path. The short hold windows let every legal and illegal release point for both burst kinds be reached within a few cycles of a write.

// File: rtl/odt_sync_pkg.sv
package odt_sync_pkg;
  typedef enum logic [1:0] {
    AL_ZERO  = 2'b00,
    AL_CL_M1 = 2'b01,
    AL_CL_M2 = 2'b10,
    AL_RSVD  = 2'b11
  } al_code_e;
endpackage

// File: rtl/odt_lat_cfg.sv
// Latency register: computes write latency minus two and captures it on load.
module odt_lat_cfg #(
  parameter int CWL_W   = 4,
  parameter int CL_W    = 5,
  parameter int DEPTH   = 16,
  parameter int DEF_LAT = 3,
  parameter int LW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CWL_W-1:0] cwl,
  input  logic [CL_W-1:0]  cl,
  input  logic [1:0]       al_code,
  output logic [LW-1:0]    lat_q,
  output logic             bad_code
);
  import odt_sync_pkg::*;
  localparam int SW = ((CWL_W > CL_W) ? CWL_W : CL_W) + 1;

  logic [CL_W-1:0] al;
  logic [SW-1:0]   sum;
  logic [LW-1:0]   lat_n;
  int              diff;

  always_comb begin
    al = '0;
    case (al_code_e'(al_code))
      AL_CL_M1: al = (cl >= CL_W'(1)) ? cl - CL_W'(1) : '0;
      AL_CL_M2: al = (cl >= CL_W'(2)) ? cl - CL_W'(2) : '0;
      default:  al = '0;
    endcase
    sum  = SW'(cwl) + SW'(al);
    diff = int'(sum) - 2;
    if (diff < 1)          lat_n = LW'(1);
    else if (diff > DEPTH) lat_n = LW'(DEPTH);
    else                   lat_n = LW'(diff);
  end

  assign bad_code = load && (al_code_e'(al_code) == AL_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_q <= LW'(DEF_LAT);
    else if (load && !bad_code) lat_q <= lat_n;
  end
endmodule

// File: rtl/odt_delay_line.sv
// Sample pipeline with a tap selected by the captured latency.
module odt_delay_line #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          din,
  input  logic [LW-1:0] lat,
  output logic          dout
);
  logic sh [DEPTH];
  logic tap;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh[0] <= 1'b0;
        else if (flush) sh[0] <= 1'b0;
        else            sh[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh[i] <= 1'b0;
        else if (flush) sh[i] <= 1'b0;
        else            sh[i] <= sh[i-1];
      end
    end
  end

  // stage k holds the sample taken k+1 edges ago; the output register adds one
  always_comb begin
    tap = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      if (lat == LW'(k + 1)) tap = sh[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout <= 1'b0;
    else if (flush) dout <= 1'b0;
    else            dout <= tap;
  end
endmodule

// File: rtl/odt_hold_chk.sv
// Tracks the remaining minimum-high cycles from pin rise and from writes.
module odt_hold_chk #(
  parameter int ODTH4 = 4,
  parameter int ODTH8 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic pin,
  input  logic wr,
  input  logic bl8,
  output logic viol_min,
  output logic viol_wr
);
  localparam int HMAX = (ODTH8 > ODTH4) ? ODTH8 : ODTH4;
  localparam int CW   = $clog2(HMAX + 1);

  logic          pin_q;
  logic [CW-1:0] hi_rem, wr_rem, wr_dec, wr_need;

  assign wr_dec  = (wr_rem != '0) ? wr_rem - CW'(1) : '0;
  assign wr_need = bl8 ? CW'(ODTH8 - 1) : CW'(ODTH4 - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      hi_rem <= '0;
      wr_rem <= '0;
    end else if (!active) begin
      pin_q  <= 1'b0;
      hi_rem <= '0;
      wr_rem <= '0;
    end else begin
      pin_q <= pin;
      if (pin) begin
        if (!pin_q)              hi_rem <= CW'(ODTH4 - 1);
        else if (hi_rem != '0)   hi_rem <= hi_rem - CW'(1);
        if (wr && wr_need > wr_dec) wr_rem <= wr_need;
        else                        wr_rem <= wr_dec;
      end else begin
        hi_rem <= '0;
        wr_rem <= '0;
      end
    end
  end

  assign viol_min = active && !pin && pin_q && (hi_rem != '0);
  assign viol_wr  = active && !pin && pin_q && (wr_rem != '0);
endmodule

// File: rtl/odt_sync_unit.sv
module odt_sync_unit #(
  parameter int CWL_W   = 4,
  parameter int CL_W    = 5,
  parameter int DEPTH   = 16,
  parameter int DEF_LAT = 3,
  parameter int ODTH4   = 4,
  parameter int ODTH8   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             dll_locked,
  input  logic             term_en,
  input  logic             pd_act_bank,
  input  logic             pd_dll_kept,
  input  logic             mode_load,
  input  logic [CWL_W-1:0] cwl,
  input  logic [CL_W-1:0]  cl,
  input  logic [1:0]       al_code,
  input  logic             odt_pin,
  input  logic             wr_cmd,
  input  logic             wr_bl8,
  input  logic             err_clr,
  output logic             odt_term_on,
  output logic             err_hold,
  output logic             err_write,
  output logic             cfg_err
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [LW-1:0] lat_q;
  logic          bad_code, sync_on, viol_min, viol_wr;

  assign sync_on = dll_locked && term_en && (cke || pd_act_bank || pd_dll_kept);

  odt_lat_cfg #(.CWL_W(CWL_W), .CL_W(CL_W), .DEPTH(DEPTH), .DEF_LAT(DEF_LAT), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .cwl(cwl), .cl(cl),
    .al_code(al_code), .lat_q(lat_q), .bad_code(bad_code)
  );

  odt_delay_line #(.DEPTH(DEPTH), .LW(LW)) u_line (
    .clk(clk), .rst_n(rst_n), .flush(!sync_on), .din(odt_pin),
    .lat(lat_q), .dout(odt_term_on)
  );

  odt_hold_chk #(.ODTH4(ODTH4), .ODTH8(ODTH8)) u_hold (
    .clk(clk), .rst_n(rst_n), .active(sync_on), .pin(odt_pin),
    .wr(wr_cmd), .bl8(wr_bl8), .viol_min(viol_min), .viol_wr(viol_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_hold  <= 1'b0;
      err_write <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      if (err_clr) begin
        err_hold  <= 1'b0;
        err_write <= 1'b0;
        cfg_err   <= 1'b0;
      end
      if (viol_min) err_hold  <= 1'b1;
      if (viol_wr)  err_write <= 1'b1;
      if (bad_code) cfg_err   <= 1'b1;
    end
  end
endmodule

// File: rtl/odt_sync_chk.sv
module odt_sync_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dll_locked,
  input logic          err_clr,
  input logic          mode_load,
  input logic [1:0]    al_code,
  input logic [LW-1:0] lat_q,
  input logic          odt_term_on,
  input logic          err_hold,
  input logic          err_write,
  input logic          cfg_err
);
  p_lat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q >= LW'(1)) && (lat_q <= LW'(DEPTH)));

  p_lat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(lat_q));

  p_rsvd_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && al_code == 2'b11) |=> (cfg_err && $stable(lat_q)));

  p_nosync_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dll_locked |=> !odt_term_on);

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hold && !err_clr) |=> err_hold);

  p_sticky_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_write && !err_clr) |=> err_write);

  p_clear_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !mode_load) |=> !cfg_err);
endmodule

bind odt_sync_unit odt_sync_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dll_locked(dll_locked), .err_clr(err_clr),
  .mode_load(mode_load), .al_code(al_code), .lat_q(lat_q),
  .odt_term_on(odt_term_on), .err_hold(err_hold), .err_write(err_write),
  .cfg_err(cfg_err)
);

// File: tb/odt_sync_unit_tb.sv
module odt_sync_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int V_CWL [NV] = '{5, 5, 6, 8, 10, 2, 3, 7};
  localparam int V_CL  [NV] = '{5, 6, 7, 11, 11, 0, 0, 9};
  localparam int V_AL  [NV] = '{0, 1, 2, 1, 1, 0, 0, 2};
  localparam int V_EXP [NV] = '{3, 8, 9, 16, 16, 1, 1, 12};

  logic clk = 0, rst_n = 0;
  logic cke = 1, dll_locked = 1, term_en = 1, pd_act_bank = 0, pd_dll_kept = 0;
  logic mode_load = 0;
  logic [3:0] cwl = 4'd5;
  logic [4:0] cl = 5'd5;
  logic [1:0] al_code = 2'b00;
  logic odt_pin = 0, wr_cmd = 0, wr_bl8 = 0, err_clr = 0;
  logic odt_term_on, err_hold, err_write, cfg_err;
  int nvec = 0, nerr = 0, meas;

  always #(CLK_PERIOD/2) clk = ~clk;

  odt_sync_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .dll_locked(dll_locked), .term_en(term_en),
    .pd_act_bank(pd_act_bank), .pd_dll_kept(pd_dll_kept), .mode_load(mode_load),
    .cwl(cwl), .cl(cl), .al_code(al_code), .odt_pin(odt_pin), .wr_cmd(wr_cmd),
    .wr_bl8(wr_bl8), .err_clr(err_clr), .odt_term_on(odt_term_on),
    .err_hold(err_hold), .err_write(err_write), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic load(input int c_wl, input int c_l, input int code);
    cwl = 4'(c_wl); cl = 5'(c_l); al_code = 2'(code); mode_load = 1;
    step(1);
    mode_load = 0;
    step(2);
  endtask

  // pin high, count edges to turn-on; returns latency in meas
  task automatic meas_on();
    int n = 0;
    odt_pin = 1;
    do begin step(1); n++; end while (!odt_term_on && n < 40);
    meas = n - 1;
    while (n < 6) begin step(1); n++; end
  endtask

  task automatic meas_off();
    int n = 0;
    odt_pin = 0;
    do begin step(1); n++; end while (odt_term_on && n < 40);
    meas = n - 1;
  endtask

  task automatic clear_flags();
    err_clr = 1; step(1); err_clr = 0;
  endtask

  // pin high for cnt edges, write at edge index wat (-1: none), then low
  task automatic pulse(input int cnt, input int wat, input bit bl8);
    odt_pin = 1; wr_bl8 = bl8;
    for (int i = 0; i < cnt; i++) begin
      wr_cmd = (i == wat);
      step(1);
    end
    wr_cmd = 0; odt_pin = 0;
    step(1);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(!odt_term_on && !err_hold && !err_write && !cfg_err, "R1 flags at reset",
          {odt_term_on, err_hold, err_write, cfg_err}, 0);
    rst_n = 1;
    step(1);
    meas_on();
    check(meas == 3, "R1 default latency", meas, 3);
    meas_off();
    step(20);

    // table walk: R2 on latency, R3 off latency, R4 clamps
    for (int v = 0; v < NV; v++) begin
      load(V_CWL[v], V_CL[v], V_AL[v]);
      step(18);
      meas_on();
      check(meas == V_EXP[v], "R2/R4 turn-on latency", meas, V_EXP[v]);
      meas_off();
      check(meas == V_EXP[v], "R3 turn-off latency", meas, V_EXP[v]);
      step(18);
    end
    check(!err_hold && !err_write, "R9 no false hold flag", {err_hold, err_write}, 0);

    // R6: field change without load has no effect
    load(5, 5, 0);
    step(4);
    cwl = 4'd9; al_code = 2'b01; cl = 5'd9;
    step(2);
    meas_on();
    check(meas == 3, "R6 fields ignored without load", meas, 3);
    meas_off();
    step(4);

    // R5: reserved code flags and keeps latency
    load(9, 9, 3);
    check(cfg_err == 1, "R5 cfg_err set", cfg_err, 1);
    meas_on();
    check(meas == 3, "R5 latency unchanged", meas, 3);
    meas_off();
    step(4);
    clear_flags();
    check(cfg_err == 0, "R11 cfg_err cleared", cfg_err, 0);

    // R8: drop lock while high, output low, stale highs flushed
    odt_pin = 1;
    step(6);
    check(odt_term_on == 1, "R8 precondition on", odt_term_on, 1);
    dll_locked = 0;
    step(1);
    check(odt_term_on == 0, "R8 low next edge", odt_term_on, 0);
    step(4);
    odt_pin = 0; dll_locked = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin step(1); if (odt_term_on) seen++; end
      check(seen == 0, "R8 pipeline flushed", seen, 0);
    end
    check(!err_hold, "R8 no hold flag on mode drop", err_hold, 0);

    // R7: cke low without power-down qualifiers -> inactive
    cke = 0;
    odt_pin = 1;
    step(8);
    check(odt_term_on == 0, "R7 cke low inactive", odt_term_on, 0);
    odt_pin = 0; step(2);
    pd_act_bank = 1;
    meas_on();
    check(meas == 3, "R7 active power-down keeps sync", meas, 3);
    meas_off(); pd_act_bank = 0;
    pd_dll_kept = 1;
    meas_on();
    check(meas == 3, "R7 precharge power-down with DLL kept", meas, 3);
    meas_off(); pd_dll_kept = 0; cke = 1;
    term_en = 0; odt_pin = 1; step(6);
    check(odt_term_on == 0, "R7 term_en low inactive", odt_term_on, 0);
    odt_pin = 0; term_en = 1; step(4);
    clear_flags();

    // R9 minimum high hold
    pulse(3, -1, 0);
    check(err_hold == 1, "R9 short high flagged", err_hold, 1);
    step(3);
    check(err_hold == 1, "R9 sticky", err_hold, 1);
    clear_flags();
    check(err_hold == 0, "R11 err_hold cleared", err_hold, 0);
    pulse(4, -1, 0);
    check(err_hold == 0, "R9 four cycles legal", err_hold, 0);

    // R10 write hold, chopped and full bursts
    step(2);
    pulse(6, 3, 0);
    check(err_write == 1, "R10 BC4 early release", err_write, 1);
    clear_flags();
    pulse(7, 3, 0);
    check(err_write == 0, "R10 BC4 legal release", err_write, 0);
    pulse(8, 3, 1);
    check(err_write == 1, "R10 BL8 early release", err_write, 1);
    clear_flags();
    check(err_write == 0, "R11 err_write cleared", err_write, 0);
    pulse(9, 3, 1);
    check(err_write == 0, "R10 BL8 legal release", err_write, 0);
    wr_cmd = 1; wr_bl8 = 1; step(1); wr_cmd = 0;
    pulse(4, -1, 1);
    check(err_write == 0, "R10 write with pin low ignored", err_write, 0);
    check(err_hold == 0, "R9 no hold flag", err_hold, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule